// File: doc/BRIEF.md
# Host Bridge Address Window Decoder

This block sits between a 32-bit CPU bus and a downstream PCI-style bus. Each CPU request is classified as one of four downstream cycles: an I/O cycle, a configuration cycle, an interrupt-acknowledge read, or a memory cycle. For that cycle the block produces the downstream address and little-endian byte enables. A request that matches no window, or has an illegal size, is flagged as an error and produces no downstream cycle.

The same block routes device interrupt pins onto two shared lines and ORs those lines into one CPU interrupt. It also translates inbound bus-master addresses. A mode input chooses how I/O offsets become port numbers: a flat 64 KiB port space, or a compressed map in which each 4 KiB page supplies 32 consecutive ports.

Requests arrive on a valid/ready channel, and results leave on a second valid/ready channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result register is empty, or is being emptied in the same cycle (`res_ready` high). A result held under back-pressure stays unchanged until it is taken. The interrupt and bus-master paths are plain combinational signals.

Top module: `hbd_window_decoder`

## Requirements
- R1: Window map. CPU addresses 0x80000000–0x807FFFFF decode as I/O (target 1). Addresses 0x80800000–0x80BFFFFF decode as configuration (target 2). The single address 0xBFFFFFF0 is interrupt-acknowledge (target 3). Addresses 0xC0000000–0xFEFFFFFF decode as memory (target 4). Target 0 means no downstream cycle.
- R2: For a configuration cycle, address bits 10:0 pass through unchanged. Bits 15:11 carry the device number, and bits 31:16 are zero. The device number is the position, counted from bit 11, of the lowest set bit among CPU address bits 11..21. If none of those bits is set, the device number is 11.
- R3: With the mode bit at 0, the I/O port address is the offset from 0x80000000 masked to its low 16 bits.
- R4: With the mode bit at 1, the I/O port address is formed from two offset fields. Offset bits 22:12 go to port bits 15:5, and offset bits 4:0 go to port bits 4:0.
- R5: The mode bit resets to 0 and is registered on each clock edge. A request accepted on a given edge uses the mode level registered on the previous edge. A change therefore never affects a request already being accepted.
- R6: A 1-byte read of 0xBFFFFFF0 yields target 3 with address 0 and byte enables 0x01. A write there is ignored: the result has target 0, error 0 and byte enables 0. A read there of any other size is an error.
- R7: Size code 0, 1 or 2 means 1, 2 or 4 bytes. The byte enables are the size mask shifted left by CPU address bits 1:0, on an 8-bit field. An unaligned access that crosses the 32-bit word boundary therefore sets bits above bit 3.
- R8: Size code 3, or an address outside every window, gives error 1 with target 0, address 0 and byte enables 0.
- R9: A result appears on `res_valid` in the cycle after its request is accepted. `req_ready` equals `!res_valid || res_ready`. A result held while `res_ready` is low keeps all of its fields.
- R10: A memory cycle's address is the CPU address minus 0xC0000000.
- R11: Device slot d, pin p is input `dev_irq[4*d+p]`, with pins A–D numbered 0–3. That input drives `irq_line[(p+d) mod 2]`. `cpu_irq` is the OR of both lines.
- R12: An inbound bus-master address at or above 0x80000000 goes to CPU memory at (address − 0x80000000), with `bm_to_cpu` = 1. A lower address loops back into the PCI memory window at the same offset, with `bm_to_cpu` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_map_mode | input | 1 | 0 = flat I/O map, 1 = compressed I/O map |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | CPU byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal |
| res_valid | output | 1 | Decode result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_target | output | 3 | 0 none, 1 I/O, 2 config, 3 int-ack, 4 memory |
| res_addr | output | 32 | Translated downstream address |
| res_be | output | 8 | Byte enables over two 32-bit words |
| res_error | output | 1 | Access hit no window or had an illegal size |
| dev_irq | input | 16 | Device interrupt pins, 4 slots × 4 pins |
| irq_line | output | 2 | Routed shared interrupt lines |
| cpu_irq | output | 1 | OR of the routed lines |
| bm_addr | input | 32 | Inbound bus-master address |
| bm_to_cpu | output | 1 | Inbound access targets CPU memory |
| bm_xlat_addr | output | 32 | Translated inbound address |

## Verification
The bench checks each window edge: the last memory byte against the first address past it, and the gap just above the configuration window, where a window check that is off by one would either accept or refuse the access.

For configuration cycles it covers several cases: a single select bit, several bits at once, and none at all. A scan run from the wrong end would report the highest set bit, and missing default handling would yield device 0 instead of 11.

It switches the I/O mode in the same cycle as a request. A design that used the live mode input would compress an access that must stay flat.

Random back-pressure tests that a stalled result is not overwritten or dropped. Unaligned accesses that cross a word boundary test that the byte enables are not truncated to 4 bits.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam int ADDR_W = 32;
  localparam int BYTES  = 4;
  localparam int BE_W   = 2 * BYTES;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_IO   = 3'd1,
    TGT_CFG  = 3'd2,
    TGT_IACK = 3'd3,
    TGT_MEM  = 3'd4
  } tgt_e;

  typedef struct packed {
    tgt_e              target;
    logic [ADDR_W-1:0] addr;
    logic [BE_W-1:0]   be;
    logic              err;
  } dec_s;
endpackage

// File: rtl/hbd_cpu_decode.sv
module hbd_cpu_decode
  import hbd_pkg::*;
#(
  parameter logic [31:0] IO_BASE   = 32'h8000_0000,
  parameter int          IO_LOG2   = 23,
  parameter logic [31:0] CFG_BASE  = 32'h8080_0000,
  parameter int          CFG_LOG2  = 22,
  parameter logic [31:0] IACK_ADDR = 32'hBFFF_FFF0,
  parameter logic [31:0] MEM_BASE  = 32'hC000_0000,
  parameter logic [31:0] MEM_END   = 32'hFF00_0000,
  parameter int          SEL_LSB   = 11,
  parameter int          NSEL      = 11,
  parameter int          PAGE_LSB  = 12,
  parameter int          PORT_BITS = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [1:0]        size,
  input  logic              compressed,
  output dec_s              dec
);
  localparam int DEV_W     = $clog2(NSEL + 1);
  localparam int PORT_W    = 16;
  localparam int PAGE_BITS = PORT_W - PORT_BITS;
  localparam logic [ADDR_W:0] IO_END  = {1'b0, IO_BASE}  + (33'd1 << IO_LOG2);
  localparam logic [ADDR_W:0] CFG_END = {1'b0, CFG_BASE} + (33'd1 << CFG_LOG2);

  logic              io_hit, cfg_hit, iack_hit, mem_hit;
  logic [DEV_W-1:0]  dev_num;
  logic [ADDR_W-1:0] io_off;
  logic [PORT_W-1:0] port;
  logic [3:0]        size_mask;
  logic [BE_W-1:0]   lanes;

  assign io_hit   = ({1'b0, addr} >= {1'b0, IO_BASE})  && ({1'b0, addr} < IO_END);
  assign cfg_hit  = ({1'b0, addr} >= {1'b0, CFG_BASE}) && ({1'b0, addr} < CFG_END);
  assign iack_hit = (addr == IACK_ADDR);
  assign mem_hit  = (addr >= MEM_BASE) && (addr < MEM_END);

  // device select: lowest set bit wins, default when none set
  always_comb begin
    dev_num = DEV_W'(NSEL);
    for (int i = NSEL - 1; i >= 0; i--) begin
      if (addr[SEL_LSB + i]) dev_num = DEV_W'(i);
    end
  end

  // I/O port formation, flat or page-compressed
  assign io_off = addr - IO_BASE;
  always_comb begin
    if (compressed)
      port = {io_off[PAGE_LSB + PAGE_BITS - 1:PAGE_LSB], io_off[PORT_BITS-1:0]};
    else
      port = io_off[PORT_W-1:0];
  end

  always_comb begin
    case (size)
      2'd0:    size_mask = 4'h1;
      2'd1:    size_mask = 4'h3;
      default: size_mask = 4'hF;
    endcase
    lanes = BE_W'(size_mask) << addr[1:0];
  end

  always_comb begin
    dec        = '0;
    dec.target = TGT_NONE;
    if (size == 2'd3) begin
      dec.err = 1'b1;
    end else if (cfg_hit) begin
      dec.target = TGT_CFG;
      dec.addr   = ADDR_W'({dev_num, addr[SEL_LSB-1:0]});
      dec.be     = lanes;
    end else if (io_hit) begin
      dec.target = TGT_IO;
      dec.addr   = ADDR_W'(port);
      dec.be     = lanes;
    end else if (iack_hit) begin
      if (!write) begin
        if (size == 2'd0) begin
          dec.target = TGT_IACK;
          dec.be     = lanes;
        end else begin
          dec.err = 1'b1;
        end
      end
    end else if (mem_hit) begin
      dec.target = TGT_MEM;
      dec.addr   = addr - MEM_BASE;
      dec.be     = lanes;
    end else begin
      dec.err = 1'b1;
    end
  end
endmodule

// File: rtl/hbd_irq_route.sv
module hbd_irq_route #(
  parameter int NDEV   = 4,
  parameter int NPIN   = 4,
  parameter int NLINES = 2
) (
  input  logic [NDEV*NPIN-1:0] pins,
  output logic [NLINES-1:0]    lines,
  output logic                 cpu_irq
);
  logic [NLINES-1:0] per_pin [NDEV*NPIN];

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
      localparam int LINE = (p + d) % NLINES;
      assign per_pin[d*NPIN + p] = NLINES'(pins[d*NPIN + p]) << LINE;
    end
  end

  always_comb begin
    lines = '0;
    for (int k = 0; k < NDEV*NPIN; k++) lines = lines | per_pin[k];
  end

  assign cpu_irq = |lines;
endmodule

// File: rtl/hbd_bm_xlat.sv
module hbd_bm_xlat #(
  parameter int          AW       = 32,
  parameter logic [31:0] CPU_BASE = 32'h8000_0000
) (
  input  logic [AW-1:0] bm_addr,
  output logic          to_cpu,
  output logic [AW-1:0] xlat
);
  always_comb begin
    to_cpu = (bm_addr >= AW'(CPU_BASE));
    xlat   = to_cpu ? (bm_addr - AW'(CPU_BASE)) : bm_addr;
  end
endmodule

// File: rtl/hbd_window_decoder.sv
module hbd_window_decoder
  import hbd_pkg::*;
#(
  parameter int NDEV = 4,
  parameter int NPIN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 io_map_mode,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [31:0]          req_addr,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [2:0]           res_target,
  output logic [31:0]          res_addr,
  output logic [7:0]           res_be,
  output logic                 res_error,
  input  logic [NDEV*NPIN-1:0] dev_irq,
  output logic [1:0]           irq_line,
  output logic                 cpu_irq,
  input  logic [31:0]          bm_addr,
  output logic                 bm_to_cpu,
  output logic [31:0]          bm_xlat_addr
);
  logic mode_q;
  dec_s dec_now, dec_q;
  logic accept;

  hbd_cpu_decode u_dec (
    .addr       (req_addr),
    .write      (req_write),
    .size       (req_size),
    .compressed (mode_q),
    .dec        (dec_now)
  );

  hbd_irq_route #(.NDEV(NDEV), .NPIN(NPIN), .NLINES(2)) u_irq (
    .pins    (dev_irq),
    .lines   (irq_line),
    .cpu_irq (cpu_irq)
  );

  hbd_bm_xlat #(.AW(32)) u_bm (
    .bm_addr (bm_addr),
    .to_cpu  (bm_to_cpu),
    .xlat    (bm_xlat_addr)
  );

  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      res_valid <= 1'b0;
      dec_q     <= '0;
    end else begin
      mode_q <= io_map_mode;
      if (accept) begin
        res_valid <= 1'b1;
        dec_q     <= dec_now;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  assign res_target = dec_q.target;
  assign res_addr   = dec_q.addr;
  assign res_be     = dec_q.be;
  assign res_error  = dec_q.err;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr)
      && $stable(res_target) && $stable(res_be) && $stable(res_error));

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_error |-> res_target == TGT_NONE && res_be == 8'h00);

  // R6
  iack_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_target == TGT_IACK |-> res_be == 8'h01 && !res_error);

  // R2
  cfg_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_target == TGT_CFG |-> res_addr[31:16] == 16'h0);

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_irq == '0 |-> !cpu_irq && irq_line == 2'b00);

  // R12
  bm_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bm_addr[31] |-> bm_to_cpu && bm_xlat_addr[31] == 1'b0);
endmodule

// File: tb/hbd_window_decoder_bench.sv
module hbd_window_decoder_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_map_mode = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_addr = 0;
  logic        req_write = 0;
  logic [1:0]  req_size = 0;
  logic        res_valid;
  logic        res_ready = 1;
  logic [2:0]  res_target;
  logic [31:0] res_addr;
  logic [7:0]  res_be;
  logic        res_error;
  logic [15:0] dev_irq = 0;
  logic [1:0]  irq_line;
  logic        cpu_irq;
  logic [31:0] bm_addr = 0;
  logic        bm_to_cpu;
  logic [31:0] bm_xlat_addr;

  int checks = 0;
  int failures = 0;
  logic stall_en = 0;

  always #2.5 clk = ~clk;

  hbd_window_decoder u_hbd_window_decoder (
    .clk(clk), .rst_n(rst_n), .io_map_mode(io_map_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size),
    .res_valid(res_valid), .res_ready(res_ready), .res_target(res_target),
    .res_addr(res_addr), .res_be(res_be), .res_error(res_error),
    .dev_irq(dev_irq), .irq_line(irq_line), .cpu_irq(cpu_irq),
    .bm_addr(bm_addr), .bm_to_cpu(bm_to_cpu), .bm_xlat_addr(bm_xlat_addr)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference of one access
  function automatic void ref_decode(input logic [31:0] a, input logic wr,
      input logic [1:0] sz, input logic md, output int tgt,
      output logic [31:0] xa, output logic [7:0] be, output logic err,
      output string tag);
    int dev;
    logic [31:0] off;
    tgt = 0; xa = 0; be = 0; err = 0; tag = "R1";
    if (sz == 2'd3) begin
      err = 1; tag = "R8";
    end else if (a >= 32'h8080_0000 && a < 32'h80C0_0000) begin
      dev = 11;
      for (int i = 10; i >= 0; i--) if (a[11+i]) dev = i;
      tgt = 2; xa = dev * 2048 + (a & 32'h7FF); tag = "R2";
    end else if (a >= 32'h8000_0000 && a < 32'h8080_0000) begin
      off = a - 32'h8000_0000;
      tgt = 1;
      if (md) begin xa = ((off >> 12) & 32'h7FF) * 32 + (off & 32'h1F); tag = "R4"; end
      else    begin xa = off & 32'hFFFF; tag = "R3"; end
    end else if (a == 32'hBFFF_FFF0) begin
      tag = "R6";
      if (!wr) begin
        if (sz == 0) tgt = 3; else err = 1;
      end
    end else if (a >= 32'hC000_0000 && a < 32'hFF00_0000) begin
      tgt = 4; xa = a - 32'hC000_0000; tag = "R10";
    end else begin
      err = 1; tag = "R8";
    end
    if (tgt != 0) be = 8'((1 << (1 << sz)) - 1) << a[1:0];
  endfunction

  // model state, updated on the same edge as the design
  logic        m_valid = 0, m_mode = 0, m_err = 0;
  int          m_tgt = 0;
  logic [31:0] m_addr = 0;
  logic [7:0]  m_be = 0;
  string       m_tag = "R9";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 0;
      m_mode  <= 0;
    end else begin
      if (req_valid && (!m_valid || res_ready)) begin
        int t; logic [31:0] x; logic [7:0] b; logic e; string g;
        ref_decode(req_addr, req_write, req_size, m_mode, t, x, b, e, g);
        m_valid <= 1; m_tgt <= t; m_addr <= x; m_be <= b; m_err <= e; m_tag <= g;
      end else if (m_valid && res_ready) begin
        m_valid <= 0;
      end
      m_mode <= io_map_mode;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      check("R9", "req_ready", 32'(req_ready), 32'(!m_valid || res_ready));
      check("R9", "res_valid", 32'(res_valid), 32'(m_valid));
      if (m_valid && res_valid) begin
        check(m_tag, "target", 32'(res_target), 32'(m_tgt));
        check(m_tag, "addr", res_addr, m_addr);
        check((m_tgt != 0) ? "R7" : m_tag, "be", 32'(res_be), 32'(m_be));
        check(m_tag, "error", 32'(res_error), 32'(m_err));
      end
    end
  end

  always @(negedge clk) res_ready <= stall_en ? 1'($urandom % 2) : 1'b1;

  task automatic send(input logic [31:0] a, input logic wr, input logic [1:0] sz);
    logic ok;
    req_valid = 1; req_addr = a; req_write = wr; req_size = sz;
    forever begin
      #1 ok = req_ready;
      @(posedge clk);
      @(negedge clk);
      if (ok) break;
    end
    req_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R9 reset state
    check("R9", "reset res_valid", 32'(res_valid), 0);
    check("R9", "reset req_ready", 32'(req_ready), 1);
    @(negedge clk);

    // R3 flat map, R7 crossing lanes
    send(32'h8000_1234, 0, 2);
    send(32'h8012_ABCF, 1, 1);
    send(32'h8000_0003, 0, 2);
    // R5 mode change in the accepting cycle: still flat
    io_map_mode = 1;
    send(32'h8000_3013, 0, 0);
    // R4 compressed map
    send(32'h8000_3013, 0, 0);
    send(32'h807F_F01F, 1, 0);
    io_map_mode = 0;
    send(32'h8000_3013, 0, 0);
    // R2 configuration device select
    send(32'h8080_2010, 0, 2);
    send(32'h8080_0804, 1, 2);
    send(32'h8080_0004, 0, 1);
    send(32'h8090_8000, 0, 0);
    send(32'h80BF_FFFF, 0, 0);
    // R6 interrupt acknowledge
    send(32'hBFFF_FFF0, 0, 0);
    send(32'hBFFF_FFF0, 1, 0);
    send(32'hBFFF_FFF0, 0, 1);
    // R10 memory and R8 errors at the edges
    send(32'hC000_1000, 0, 2);
    send(32'hFEFF_FFFE, 1, 1);
    send(32'hFF00_0000, 0, 0);
    send(32'h0000_1000, 0, 0);
    send(32'h80C0_0000, 0, 0);
    send(32'hC000_0000, 0, 3);
    send(32'hBFFF_FFEF, 0, 0);

    // R9 back-pressure with mixed traffic and mode toggling
    stall_en = 1;
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      case (n % 5)
        0: a = 32'h8000_0000 | ($urandom & 32'h007F_FFFF);
        1: a = 32'h8080_0000 | ($urandom & 32'h003F_FFFF);
        2: a = 32'hC000_0000 + ($urandom % 32'h3F00_0000);
        3: a = 32'hBFFF_FFF0;
        default: a = $urandom;
      endcase
      if (n % 7 == 0) io_map_mode = ~io_map_mode;
      send(a, 1'($urandom % 2), 2'($urandom % 4));
    end
    stall_en = 0;
    repeat (4) @(negedge clk);

    // R11 interrupt routing
    dev_irq = 16'h0001; #1;
    check("R11", "slot0 pinA line", 32'(irq_line), 32'b01);
    dev_irq = 16'h0010; #1;
    check("R11", "slot1 pinA line", 32'(irq_line), 32'b10);
    dev_irq = 16'h0800; #1;
    check("R11", "slot2 pinD line", 32'(irq_line), 32'b10);
    check("R11", "cpu_irq", 32'(cpu_irq), 1);
    dev_irq = 16'h2004; #1;
    check("R11", "slot3 pinB + slot0 pinC", 32'(irq_line), 32'b01);
    dev_irq = 16'h0000; #1;
    check("R11", "idle cpu_irq", 32'(cpu_irq), 0);

    // R12 bus-master inbound
    bm_addr = 32'h8000_1234; #1;
    check("R12", "to_cpu high", 32'(bm_to_cpu), 1);
    check("R12", "cpu offset", bm_xlat_addr, 32'h0000_1234);
    bm_addr = 32'h7FFF_FFFF; #1;
    check("R12", "to_cpu low", 32'(bm_to_cpu), 0);
    check("R12", "loopback offset", bm_xlat_addr, 32'h7FFF_FFFF);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule